// File: doc/BRIEF.md
# IOTLB Invalidation Granularity Selector

This block decides how a range of translation-cache entries should be invalidated. A request arrives with a one-cycle start pulse. It carries a requested granularity, a domain identifier, a byte start address, a page count, and a snapshot of the unit's capabilities. The capabilities are page-selective support, the largest address-mask exponent allowed, and the drain-read and drain-write flags.

For a page request, the block searches upward from exponent 0, one candidate per cycle. It looks for the smallest naturally aligned block of 2^am pages that holds the whole range. If it finds one, it reports page granularity with that exponent. It reports domain granularity, with exponent 0, in three cases: page-selective mode is unsupported, the start address is not on a 4 KiB boundary, or no exponent up to the limit fits. A global request passes through with the domain id forced to zero. Every decision ends with a one-cycle done pulse. The results are held until the next decision.

The block only chooses the granularity. Building the invalidation descriptor from its outputs and submitting it to a queue are left to the neighbouring logic.

Top module: `iotlb_gran_sel`

## Requirements
- R1: After reset, done and busy are 0, and gran_out, am_out, did_out, drain_rd and drain_wr are all 0.
- R2: A request with req_gran = 1 (global) gives gran_out = 1, am_out = 0 and did_out = 0, whatever domain id was supplied.
- R3: A request with req_gran = 2 (domain), or with the unused code 0, gives gran_out = 2, am_out = 0, and did_out equal to the supplied domain id.
- R4: A request with req_gran = 3 (page) while cap_psi = 0 gives gran_out = 2 and am_out = 0.
- R5: A page request whose start_addr bits [11:0] are not all zero gives gran_out = 2 and am_out = 0.
- R6: For an aligned page request with cap_psi = 1, let P = start_addr >> 12 and let N be the page count. The block picks the smallest am, from 0 up to cap_max_am, for which (P mod 2^am) + N <= 2^am. It then gives gran_out = 3 and am_out = am. A count of 0 therefore gives am 0.
- R7: If no am up to cap_max_am satisfies the R6 condition, the result is gran_out = 2 with am_out = 0.
- R8: drain_rd and drain_wr equal cap_drain_rd and cap_drain_wr as sampled with the accepted start pulse. Changes to any request input after that start do not affect the result.
- R9: The evaluation takes L cycles. L is 1 for a request that needs no search, am+1 for an accepted candidate am, and cap_max_am+1 when no candidate fits. busy is high during exactly those L cycles following the start edge. done is then high for exactly one cycle, and busy is low while done is high.
- R10: A start pulse that arrives while busy is high is ignored. Outputs change only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse, accepted when idle |
| req_gran | input | 2 | Requested granularity: 1 global, 2 domain, 3 page |
| domain_id | input | DID_W | Domain identifier |
| start_addr | input | ADDR_W | Byte start address of the range |
| page_cnt | input | CNT_W | Number of 4 KiB pages in the range |
| cap_psi | input | 1 | Page-selective invalidation supported |
| cap_max_am | input | AM_W | Largest permitted address-mask exponent |
| cap_drain_rd | input | 1 | Drain-read capability |
| cap_drain_wr | input | 1 | Drain-write capability |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle pulse when a decision is made |
| gran_out | output | 2 | Chosen granularity: 1 global, 2 domain, 3 page |
| am_out | output | AM_W | Chosen address-mask exponent |
| did_out | output | DID_W | Domain id for the command, zero when global |
| drain_rd | output | 1 | Drain-read bit for the command |
| drain_wr | output | 1 | Drain-write bit for the command |

## Verification
The search counter is the only state that changes during a request. A counter that starts wrong, skips a value or stops at the wrong limit shows up in two ways. The done pulse arrives in a different cycle from the one predicted by R9. The am_out value, or the choice between page and domain, also differs. Both are visible in the cycle where done is expected, and that cycle can be at most cap_max_am+2 cycles after start. A corrupted latch of the request inputs shows up in did_out or the drain bits in that same done cycle. A bad state register shows up as busy and done overlapping, or as an extra done pulse.

// File: rtl/iotlb_gran_pkg.sv
package iotlb_gran_pkg;
  typedef enum logic [1:0] {
    GR_NONE   = 2'd0,
    GR_GLOBAL = 2'd1,
    GR_DOMAIN = 2'd2,
    GR_PAGE   = 2'd3
  } gran_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } sel_state_e;

  localparam int PAGE_SHIFT = 12;
endpackage

// File: rtl/iotlb_gran_fit.sv
module iotlb_gran_fit #(
  parameter int PG_W  = 36,
  parameter int CNT_W = 16,
  parameter int AM_W  = 6
) (
  input  logic [PG_W-1:0]  page_num,
  input  logic [CNT_W-1:0] count,
  input  logic [AM_W-1:0]  am,
  output logic             fits
);
  localparam int BLK_MAX = 2 ** AM_W;
  localparam int WIDEST  = (PG_W > CNT_W) ? PG_W : CNT_W;
  localparam int SUM_W   = ((WIDEST > BLK_MAX) ? WIDEST : BLK_MAX) + 1;

  logic [SUM_W-1:0] blk;
  logic [SUM_W-1:0] offset;
  logic [SUM_W-1:0] span_end;

  always_comb begin
    blk      = {{(SUM_W-1){1'b0}}, 1'b1} << am;
    offset   = {{(SUM_W-PG_W){1'b0}}, page_num} & (blk - 1'b1);
    span_end = offset + {{(SUM_W-CNT_W){1'b0}}, count};
    fits     = (span_end <= blk);
  end
endmodule

// File: rtl/iotlb_gran_ctrl.sv
module iotlb_gran_ctrl
  import iotlb_gran_pkg::*;
#(
  parameter int AM_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            search_ok,
  input  logic            is_global,
  input  logic            fits,
  input  logic [AM_W-1:0] max_am,
  output logic            accept,
  output logic            busy,
  output logic [AM_W-1:0] cand,
  output logic            fin,
  output gran_e           fin_gran
);
  sel_state_e      st_q, st_d;
  logic [AM_W-1:0] cand_q, cand_d;

  always_comb begin
    st_d     = st_q;
    cand_d   = cand_q;
    fin      = 1'b0;
    fin_gran = GR_DOMAIN;
    accept   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          st_d   = ST_EVAL;
          cand_d = '0;
        end
      end
      ST_EVAL: begin
        if (!search_ok) begin
          fin      = 1'b1;
          fin_gran = is_global ? GR_GLOBAL : GR_DOMAIN;
        end else if (fits) begin
          fin      = 1'b1;
          fin_gran = GR_PAGE;
        end else if (cand_q >= max_am) begin
          fin      = 1'b1;
          fin_gran = GR_DOMAIN;
        end else begin
          cand_d = cand_q + 1'b1;
        end
        if (fin) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cand_q <= '0;
    end else begin
      st_q   <= st_d;
      cand_q <= cand_d;
    end
  end

  assign busy = (st_q == ST_EVAL);
  assign cand = cand_q;
endmodule

// File: rtl/iotlb_gran_sel.sv
module iotlb_gran_sel
  import iotlb_gran_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 16,
  parameter int AM_W   = 6,
  parameter int DID_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        req_gran,
  input  logic [DID_W-1:0]  domain_id,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  page_cnt,
  input  logic              cap_psi,
  input  logic [AM_W-1:0]   cap_max_am,
  input  logic              cap_drain_rd,
  input  logic              cap_drain_wr,
  output logic              busy,
  output logic              done,
  output logic [1:0]        gran_out,
  output logic [AM_W-1:0]   am_out,
  output logic [DID_W-1:0]  did_out,
  output logic              drain_rd,
  output logic              drain_wr
);
  localparam int PG_W = ADDR_W - PAGE_SHIFT;

  logic             accept, fin, fits;
  gran_e            fin_gran;
  logic [AM_W-1:0]  cand;

  logic [PG_W-1:0]  page_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AM_W-1:0]  max_q;
  logic [DID_W-1:0] did_q;
  logic             glob_q, search_q, drd_q, dwr_q;
  logic             search_in;

  assign search_in = (req_gran == GR_PAGE) && cap_psi &&
                     (start_addr[PAGE_SHIFT-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      cnt_q    <= '0;
      max_q    <= '0;
      did_q    <= '0;
      glob_q   <= 1'b0;
      search_q <= 1'b0;
      drd_q    <= 1'b0;
      dwr_q    <= 1'b0;
    end else if (accept) begin
      page_q   <= start_addr[ADDR_W-1:PAGE_SHIFT];
      cnt_q    <= page_cnt;
      max_q    <= cap_max_am;
      did_q    <= domain_id;
      glob_q   <= (req_gran == GR_GLOBAL);
      search_q <= search_in;
      drd_q    <= cap_drain_rd;
      dwr_q    <= cap_drain_wr;
    end
  end

  iotlb_gran_fit #(.PG_W(PG_W), .CNT_W(CNT_W), .AM_W(AM_W)) u_fit (
    .page_num (page_q),
    .count    (cnt_q),
    .am       (cand),
    .fits     (fits)
  );

  iotlb_gran_ctrl #(.AM_W(AM_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .search_ok (search_q),
    .is_global (glob_q),
    .fits      (fits),
    .max_am    (max_q),
    .accept    (accept),
    .busy      (busy),
    .cand      (cand),
    .fin       (fin),
    .fin_gran  (fin_gran)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      gran_out <= '0;
      am_out   <= '0;
      did_out  <= '0;
      drain_rd <= 1'b0;
      drain_wr <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        gran_out <= fin_gran;
        am_out   <= (fin_gran == GR_PAGE) ? cand : '0;
        did_out  <= (fin_gran == GR_GLOBAL) ? '0 : did_q;
        drain_rd <= drd_q;
        drain_wr <= dwr_q;
      end
    end
  end
endmodule

// File: rtl/iotlb_gran_sel_chk.sv
module iotlb_gran_sel_chk #(
  parameter int AM_W  = 6,
  parameter int DID_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [1:0]       gran_out,
  input logic [AM_W-1:0]  am_out,
  input logic [DID_W-1:0] did_out
);
  localparam int LIM = 2 ** AM_W;
  logic [AM_W+1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_search_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= (AM_W+2)'(LIM));
  assert_global_did_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gran_out == 2'd1) |-> did_out == '0);
  assert_nonpage_am_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && gran_out != 2'd3) |-> am_out == '0);
  assert_valid_gran_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> gran_out != 2'd0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(gran_out) && $stable(am_out) && $stable(did_out)));
endmodule

bind iotlb_gran_sel iotlb_gran_sel_chk #(.AM_W(AM_W), .DID_W(DID_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .gran_out (gran_out),
  .am_out   (am_out),
  .did_out  (did_out)
);

// File: tb/iotlb_gran_sel_test.sv
module iotlb_gran_sel_test;
  localparam int ADDR_W = 48;
  localparam int CNT_W  = 16;
  localparam int AM_W   = 6;
  localparam int DID_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic [1:0]        req_gran;
  logic [DID_W-1:0]  domain_id;
  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  page_cnt;
  logic              cap_psi;
  logic [AM_W-1:0]   cap_max_am;
  logic              cap_drain_rd, cap_drain_wr;
  logic              busy, done;
  logic [1:0]        gran_out;
  logic [AM_W-1:0]   am_out;
  logic [DID_W-1:0]  did_out;
  logic              drain_rd, drain_wr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  iotlb_gran_sel #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .AM_W(AM_W), .DID_W(DID_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_gran(req_gran),
    .domain_id(domain_id), .start_addr(start_addr), .page_cnt(page_cnt),
    .cap_psi(cap_psi), .cap_max_am(cap_max_am), .cap_drain_rd(cap_drain_rd),
    .cap_drain_wr(cap_drain_wr), .busy(busy), .done(done), .gran_out(gran_out),
    .am_out(am_out), .did_out(did_out), .drain_rd(drain_rd), .drain_wr(drain_wr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: expected granularity, exponent and latency
  task automatic model(input int rq, input longint unsigned addr, input int cnt,
                       input bit psi, input int mx,
                       output int g, output int am, output int lat);
    longint unsigned pg, blk;
    bit found;
    am = 0; lat = 1;
    if (rq == 1) g = 1;
    else if (rq != 3 || !psi || (addr % 4096) != 0) g = 2;
    else begin
      pg = addr / 4096;
      found = 0;
      for (int a = 0; a <= mx; a++) begin
        if (!found) begin
          blk = 64'd1 << a;
          if ((pg % blk) + longint'(cnt) <= blk) begin
            found = 1; g = 3; am = a; lat = a + 1;
          end
        end
      end
      if (!found) begin g = 2; am = 0; lat = mx + 1; end
    end
  endtask

  task automatic run(input string req, input int rq, input int did,
                     input longint unsigned addr, input int cnt, input bit psi,
                     input int mx, input bit drd, input bit dwr, input bit poke);
    int g, am, lat;
    model(rq, addr, cnt, psi, mx, g, am, lat);
    @(negedge clk);
    start = 1; req_gran = 2'(rq); domain_id = DID_W'(did);
    start_addr = ADDR_W'(addr); page_cnt = CNT_W'(cnt); cap_psi = psi;
    cap_max_am = AM_W'(mx); cap_drain_rd = drd; cap_drain_wr = dwr;
    @(negedge clk);
    start = 0;
    // scramble request inputs after acceptance (R8)
    domain_id = ~domain_id; cap_drain_rd = ~drd; cap_drain_wr = ~dwr;
    req_gran = 2'd1; cap_psi = ~psi; page_cnt = ~page_cnt;
    for (int n = 1; n <= lat + 1; n++) begin
      if (poke && n == 1) start = 1;   // R10: ignored while busy
      chk(busy == (n <= lat), "R9", {req, " busy"}, busy, (n <= lat));
      chk(done == (n == lat + 1), "R9", {req, " done"}, done, (n == lat + 1));
      if (n == lat + 1) begin
        chk(gran_out == 2'(g), req, "gran", gran_out, g);
        chk(am_out == AM_W'(am), req, "am", am_out, am);
        chk(did_out == DID_W'(g == 1 ? 0 : did), req, "did", did_out, g == 1 ? 0 : did);
        chk(drain_rd == drd, "R8", "drain_rd", drain_rd, drd);
        chk(drain_wr == dwr, "R8", "drain_wr", drain_wr, dwr);
      end
      @(negedge clk);
      start = 0;
    end
    chk(!done && !busy, poke ? "R10" : "R9", "quiet after done", done, 0);
    chk(gran_out == 2'(g), "R10", "held gran", gran_out, g);
  endtask

  initial begin
    rst_n = 0; start = 0; req_gran = 0; domain_id = 0; start_addr = 0;
    page_cnt = 0; cap_psi = 0; cap_max_am = 0; cap_drain_rd = 0; cap_drain_wr = 0;
    repeat (3) @(negedge clk);
    chk(!done && !busy && gran_out == 0 && am_out == 0 && did_out == 0 &&
        !drain_rd && !drain_wr, "R1", "reset state", {done, busy, gran_out}, 0);
    rst_n = 1;
    @(negedge clk);
    run("R2", 1, 16'h1234, 64'h5000, 3, 1, 5, 1, 0, 0);
    run("R3", 2, 16'h00aa, 64'h8000, 1, 1, 5, 0, 1, 0);
    run("R3", 0, 16'h0055, 64'h8000, 1, 1, 5, 1, 1, 0);
    run("R4", 3, 16'h0007, 64'h10000, 1, 0, 5, 0, 0, 0);
    run("R5", 3, 16'h0008, 64'h10010, 1, 1, 5, 1, 0, 0);
    run("R6", 3, 16'h0009, 64'h10000, 1, 1, 5, 0, 1, 0);
    run("R6", 3, 16'h000a, 64'h5000, 4, 1, 9, 1, 1, 0);
    run("R6", 3, 16'h000b, 64'h6000, 2, 1, 1, 0, 0, 0);
    run("R6", 3, 16'h000c, 64'h7000, 0, 1, 3, 0, 0, 0);
    run("R7", 3, 16'h000d, 64'h5000, 4, 1, 3, 1, 0, 0);
    run("R7", 3, 16'h000e, 64'h3000, 2, 1, 0, 0, 1, 0);
    run("R10", 3, 16'h000f, 64'h5000, 4, 1, 9, 1, 1, 1);
    for (int i = 0; i < 20; i++) begin
      run("R6", 3, i, longint'(i * 7 + 3) * 4096, i % 11 + 1, 1, i % 8, i[0], i[1], 0);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule